// File: doc/BRIEF.md
# Coherency unit control register block

This block is the software-visible register file for the control unit of a multicore cluster. It sits on a simple register bus with these signals:

- a byte address;
- a write strobe;
- an access size given as a byte count;
- write data;
- read data.

It decodes a 256-byte window. Inside that window it holds a one-bit enable, a read-only configuration word derived from the core-count parameter, and a 32-bit per-core power-status word. The power-status word can be read and written at any of its four byte offsets. Every other offset in the window is a placeholder that reads as zero and discards writes.

Read data is a pure function of the address and the stored state, so a read completes in the cycle that presents the address. A write is committed on the next rising clock edge. A write to the power-status word at byte offset k with size s replaces the s bytes starting at byte k. Lanes that would fall beyond bit 31 are dropped. The remaining bytes keep their value.

Top module: `coh_ctrl_regs`

## Requirements
- R1: While `rst_ni` is low, and after it is released, the enable bit and the whole power-status word are zero. Reads at 0x00 and 0x08 return 0.
- R2: A write to offset 0x00 stores bit 0 of `wdata_i` and discards bits 31:1. A read at 0x00 returns the stored bit in bit 0, with bits 31:1 zero.
- R3: A read at 0x04 returns NUM_CORES−1 in bits 3:0 and a run of NUM_CORES ones starting at bit 4, which is 0x10 for one core. Writes to 0x04 change nothing.
- R4: A read at 0x08+k, for k = 0..3, returns the power-status word shifted right by 8·k bits, with zeros filled in at the top.
- R5: A write at 0x08+k replaces the status bits selected by the size mask shifted left by 8·k with the equally masked and shifted write data. The size mask is 0xFF for size 1, 0xFFFF for size 2 and 0xFFFFFFFF for size 4. All other status bits keep their value.
- R6: Bits of a shifted status write that land above bit 31 are discarded. For example, a write at 0x0B changes only bits 31:24.
- R7: `size_i` is the byte count of the access, and only the values 1, 2 and 4 are legal. A write with any other value changes neither the enable bit nor the status word.
- R8: Offsets 0x0C, 0x40, 0x44, 0x50, 0x54 and every offset other than 0x00, 0x04 and 0x08–0x0B read as zero. Writes to them leave the enable bit and the status word unchanged.
- R9: `rdata_o` follows `addr_i` in the same cycle. A write becomes visible only after the rising edge that samples it, so in the cycle before that edge a read still returns the old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 8 | Byte offset within the 256-byte window |
| wr_en_i | input | 1 | Write strobe, sampled on the rising edge |
| size_i | input | 3 | Access size as a byte count (1, 2 or 4 are legal) |
| wdata_i | input | 32 | Write data, least significant byte aligned |
| rdata_o | output | 32 | Combinational read data for `addr_i` |

## Verification
The bound checker checks the following on every cycle:

- the configuration constant;
- the zero read-back of placeholder offsets;
- the right-shifted status views;
- the bit-0-only capture of the enable;
- that illegal sizes and writes to other offsets leave the status word untouched;
- that a write at 0x0B preserves bits 23:0.

Only the bench's scenarios can show the full lane-merge arithmetic across sizes and offsets. They also cover the old-value-before-edge timing of a read that overlaps a write, and the clearing of state by a reset in the middle of the run. The bench checks these against a reference model, using random mixes of sizes, offsets and data.

// File: rtl/coh_ctrl_pkg.sv
package coh_ctrl_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned LANES  = DATA_W / 8;
  localparam int unsigned LANE_W = $clog2(LANES);

  localparam logic [ADDR_W-1:0] OFF_ENABLE = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_CONFIG = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_PWR    = 8'h08;

  typedef struct packed {
    logic enable;
    logic config_w;
    logic pwr;
  } reg_sel_t;

  function automatic logic [DATA_W-1:0] size_mask(input logic [2:0] sz);
    case (sz)
      3'd1:    size_mask = DATA_W'(32'h0000_00FF);
      3'd2:    size_mask = DATA_W'(32'h0000_FFFF);
      default: size_mask = '1;
    endcase
  endfunction
endpackage

// File: rtl/coh_addr_dec.sv
module coh_addr_dec
  import coh_ctrl_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [2:0]        size_i,
  output reg_sel_t          sel_o,
  output logic [LANE_W-1:0] lane_o,
  output logic              wr_ok_o
);
  logic size_legal;

  always_comb begin
    size_legal      = (size_i == 3'd1) || (size_i == 3'd2) || (size_i == 3'd4);
    sel_o.enable    = (addr_i == OFF_ENABLE);
    sel_o.config_w  = (addr_i == OFF_CONFIG);
    sel_o.pwr       = (addr_i[ADDR_W-1:LANE_W] == OFF_PWR[ADDR_W-1:LANE_W]);
    lane_o          = addr_i[LANE_W-1:0];
    wr_ok_o         = wr_en_i && size_legal;
  end
endmodule

// File: rtl/coh_cfg_word.sv
module coh_cfg_word
  import coh_ctrl_pkg::*;
#(
  parameter int unsigned NUM_CORES = 1
) (
  output logic [DATA_W-1:0] cfg_o
);
  localparam int unsigned CNT_W  = 4;
  localparam int unsigned MASK_LSB = 4;

  initial begin
    if (NUM_CORES < 1 || NUM_CORES > 16)
      $error("coh_cfg_word: NUM_CORES must be 1..16");
  end

  always_comb begin
    cfg_o = '0;
    cfg_o[CNT_W-1:0] = CNT_W'(NUM_CORES - 1);
    cfg_o[MASK_LSB +: NUM_CORES] = '1;
  end
endmodule

// File: rtl/coh_pwr_status.sv
module coh_pwr_status
  import coh_ctrl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [LANE_W-1:0] lane_i,
  input  logic [2:0]        size_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] status_o
);
  logic [DATA_W-1:0] smask, mask_sh, data_sh;
  logic [LANE_W+2:0] shamt;

  always_comb begin
    smask   = size_mask(size_i);
    shamt   = {lane_i, 3'b000};
    // shifting in DATA_W bits drops lanes past the top
    mask_sh = smask << shamt;
    data_sh = (wdata_i & smask) << shamt;
  end

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    logic [7:0] byte_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                     byte_q <= '0;
      else if (we_i && mask_sh[8*b])   byte_q <= data_sh[8*b +: 8];
    end
    assign status_o[8*b +: 8] = byte_q;
  end
endmodule

// File: rtl/coh_ctrl_regs.sv
module coh_ctrl_regs
  import coh_ctrl_pkg::*;
#(
  parameter int unsigned NUM_CORES = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        addr_i,
  input  logic              wr_en_i,
  input  logic [2:0]        size_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o
);
  reg_sel_t          sel;
  logic [LANE_W-1:0] lane;
  logic              wr_ok;
  logic              ctrl_q;
  logic [DATA_W-1:0] status_q;
  logic [DATA_W-1:0] cfg_word;
  logic [LANE_W+2:0] rd_shamt;

  coh_addr_dec u_dec (
    .addr_i  (addr_i),
    .wr_en_i (wr_en_i),
    .size_i  (size_i),
    .sel_o   (sel),
    .lane_o  (lane),
    .wr_ok_o (wr_ok)
  );

  coh_cfg_word #(.NUM_CORES(NUM_CORES)) u_cfg (
    .cfg_o (cfg_word)
  );

  coh_pwr_status u_pwr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (wr_ok && sel.pwr),
    .lane_i   (lane),
    .size_i   (size_i),
    .wdata_i  (wdata_i),
    .status_o (status_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  ctrl_q <= 1'b0;
    else if (wr_ok && sel.enable) ctrl_q <= wdata_i[0];
  end

  always_comb begin
    rd_shamt = {lane, 3'b000};
    unique case (1'b1)
      sel.enable:   rdata_o = {{(DATA_W-1){1'b0}}, ctrl_q};
      sel.config_w: rdata_o = cfg_word;
      sel.pwr:      rdata_o = status_q >> rd_shamt;
      default:      rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/coh_ctrl_regs_chk.sv
module coh_ctrl_regs_chk #(
  parameter int unsigned NUM_CORES = 1
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [7:0]  addr_i,
  input logic        wr_en_i,
  input logic [2:0]  size_i,
  input logic [31:0] wdata_i,
  input logic [31:0] rdata_o,
  input logic        ctrl_q,
  input logic [31:0] status_q
);
  localparam logic [31:0] CFG_EXP =
    32'(((64'd1 << NUM_CORES) - 64'd1) << 4) | 32'(NUM_CORES - 1);

  logic sz_ok, pwr_hit, known;
  assign sz_ok   = (size_i == 3'd1) || (size_i == 3'd2) || (size_i == 3'd4);
  assign pwr_hit = (addr_i >= 8'h08) && (addr_i <= 8'h0B);
  assign known   = (addr_i == 8'h00) || (addr_i == 8'h04) || pwr_hit;

  AST_ENABLE_BIT0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 8'h00 && sz_ok) |=> (ctrl_q == $past(wdata_i[0]))); // R2
  AST_ENABLE_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == 8'h00) |-> (rdata_o == {31'b0, ctrl_q})); // R2
  AST_CFG_CONST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == 8'h04) |-> (rdata_o == CFG_EXP)); // R3
  AST_PWR_VIEW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_hit |-> (rdata_o == (status_q >> {addr_i[1:0], 3'b000}))); // R4
  AST_TOP_LANE_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 8'h0B && sz_ok) |=> (status_q[23:0] == $past(status_q[23:0]))); // R6
  AST_BAD_SIZE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !sz_ok) |=> ($stable(ctrl_q) && $stable(status_q))); // R7
  AST_STATUS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && pwr_hit && sz_ok) |=> $stable(status_q)); // R8
  AST_ZERO_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !known |-> (rdata_o == 32'h0)); // R8
endmodule

bind coh_ctrl_regs coh_ctrl_regs_chk #(.NUM_CORES(NUM_CORES)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .addr_i   (addr_i),
  .wr_en_i  (wr_en_i),
  .size_i   (size_i),
  .wdata_i  (wdata_i),
  .rdata_o  (rdata_o),
  .ctrl_q   (ctrl_q),
  .status_q (status_q)
);

// File: tb/tb_coh_ctrl_regs.sv
module tb_coh_ctrl_regs;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CORES  = 1;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  size = 3'd4;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int n_chk = 0;
  int n_bad = 0;

  logic        m_ctrl = 1'b0;
  logic [31:0] m_stat = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  coh_ctrl_regs #(.NUM_CORES(NUM_CORES)) dut (
    .clk_i   (clk),
    .rst_ni  (rst_ni),
    .addr_i  (addr),
    .wr_en_i (wr_en),
    .size_i  (size),
    .wdata_i (wdata),
    .rdata_o (rdata)
  );

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    logic [31:0] cfg;
    cfg = 32'(((64'd1 << NUM_CORES) - 64'd1) << 4) | 32'(NUM_CORES - 1);
    if (a == 8'h00) return {31'b0, m_ctrl};
    if (a == 8'h04) return cfg;
    if (a >= 8'h08 && a <= 8'h0B) return m_stat >> (8 * (a - 8'h08));
    return 32'h0;
  endfunction

  function automatic void model_write(input logic [7:0] a, input logic [2:0] s,
                                      input logic [31:0] d);
    logic [63:0] msk, dat;
    if (!(s == 3'd1 || s == 3'd2 || s == 3'd4)) return;
    if (a == 8'h00) m_ctrl = d[0];
    else if (a >= 8'h08 && a <= 8'h0B) begin
      msk = (s == 3'd1) ? 64'hFF : (s == 3'd2) ? 64'hFFFF : 64'hFFFF_FFFF;
      dat = {32'b0, d} & msk;
      msk = msk << (8 * (a - 8'h08));
      dat = dat << (8 * (a - 8'h08));
      m_stat = (m_stat & ~msk[31:0]) | dat[31:0];
    end
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input string req, input logic [7:0] a);
    @(negedge clk);
    addr = a; wr_en = 1'b0;
    #1 check(req, rdata, exp_read(a));
  endtask

  task automatic wr(input logic [7:0] a, input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    addr = a; size = s; wdata = d; wr_en = 1'b1;
    @(posedge clk);
    model_write(a, s, d);
    #1 wr_en = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] pick [12];
    pick = '{8'h00, 8'h04, 8'h08, 8'h09, 8'h0A, 8'h0B, 8'h0C, 8'h40, 8'h44, 8'h50, 8'h54, 8'h01};
    void'($urandom(32'd1234));

    #1 check("R1 reset ctrl", rdata, 32'h0);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    rd("R1 enable after reset", 8'h00);
    rd("R1 status after reset", 8'h08);
    rd("R3 config", 8'h04);
    check("R3 config one core", rdata, 32'h0000_0010);

    wr(8'h00, 3'd4, 32'hFFFF_FFFE); rd("R2 bit0 clear", 8'h00);
    wr(8'h00, 3'd4, 32'h0000_0003); rd("R2 bit0 set", 8'h00);
    check("R2 only bit0", rdata, 32'h1);
    wr(8'h04, 3'd4, 32'hFFFF_FFFF); rd("R3 config write ignored", 8'h04);

    wr(8'h08, 3'd4, 32'h1122_3344);
    rd("R4 view 0", 8'h08); rd("R4 view 1", 8'h09);
    rd("R4 view 2", 8'h0A); rd("R4 view 3", 8'h0B);
    check("R4 view 3 literal", rdata, 32'h0000_0011);
    wr(8'h0A, 3'd1, 32'hFFFF_FFAB); rd("R5 byte merge", 8'h08);
    check("R5 byte merge literal", rdata, 32'h11AB_3344);
    wr(8'h09, 3'd2, 32'hFFFF_CDEF); rd("R5 half merge", 8'h08);
    check("R5 half merge literal", rdata, 32'h11CD_EF44);
    wr(8'h0B, 3'd4, 32'h9988_7766); rd("R6 word at top lane", 8'h08);
    check("R6 word at top lane literal", rdata, 32'h66CD_EF44);
    wr(8'h0B, 3'd2, 32'h0000_5555); rd("R6 half at top lane", 8'h08);

    wr(8'h08, 3'd3, 32'hDEAD_BEEF); rd("R7 size 3 ignored", 8'h08);
    wr(8'h00, 3'd0, 32'h0000_0000); rd("R7 size 0 ignored", 8'h00);
    wr(8'h09, 3'd7, 32'h0000_0000); rd("R7 size 7 ignored", 8'h08);

    foreach (pick[i]) if (i >= 6) begin
      wr(pick[i], 3'd4, 32'hFFFF_FFFF);
      rd("R8 placeholder reads zero", pick[i]);
      rd("R8 status kept", 8'h08);
      rd("R8 enable kept", 8'h00);
    end

    // overlapping read/write: old value before edge, new after
    @(negedge clk);
    addr = 8'h08; size = 3'd4; wdata = 32'hCAFE_F00D; wr_en = 1'b1;
    #1 check("R9 old before edge", rdata, exp_read(8'h08));
    @(posedge clk);
    model_write(8'h08, 3'd4, 32'hCAFE_F00D);
    #1 wr_en = 1'b0;
    check("R9 new after edge", rdata, 32'hCAFE_F00D);

    @(negedge clk); rst_ni = 1'b0;
    m_ctrl = 1'b0; m_stat = '0;
    addr = 8'h08;
    #1 check("R1 async reset status", rdata, 32'h0);
    @(negedge clk); rst_ni = 1'b1;
    rd("R1 enable after mid reset", 8'h00);

    for (int n = 0; n < 600; n++) begin
      logic [7:0]  a;
      logic [2:0]  s;
      logic [31:0] d;
      a = ($urandom % 8 == 0) ? 8'($urandom) : pick[$urandom % 12];
      s = ($urandom % 6 == 0) ? 3'($urandom) : ((($urandom % 3) == 0) ? 3'd1 :
          (($urandom % 2) == 0) ? 3'd2 : 3'd4);
      d = $urandom;
      if ($urandom % 2) wr(a, s, d);
      rd("R5 random read", pick[$urandom % 12]);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule